// File: doc/BRIEF.md
# DMA Channel Condition Register Bank

This block is the register bank for one descriptor-driven DMA channel. A simple 32-bit register bus reaches it with an address, a write strobe, write data and combinational read data. It holds a 16-bit channel status word, a command pointer and three condition selectors. The selectors cover interrupt, branch and wait. Software cannot write the status word directly. It changes the word through a control register, where the upper half of the write data is a per-bit enable and the lower half carries the new bit values. The device side can also load the low status byte through a strobe.

Each selector holds an 8-bit mask and an 8-bit value. The selector raises its condition when the low status byte, ANDed with the mask, equals the value. A descriptor being executed presents three 2-bit decision fields. The block resolves each field against its condition and returns whether to raise an interrupt, take a branch, or wait.

Top module: `dma_cond_regs`

## Requirements
- R1: After a synchronous active-high reset, every register reads as zero and all three conditions are 1.
- R2: A write at offset 0x00 updates only those status bits [15:0] whose enable bit in wdata[31:16] is 1. Each such bit takes its value from wdata[15:0]. All other status bits keep their old value.
- R3: Reads at offset 0x00 and at offset 0x04 both return the status word in bits [15:0], with bits [31:16] at zero.
- R4: A write at offset 0x04 has no effect on the status word.
- R5: The command pointer at offset 0x0C stores wdata[31:4] and always reads bits [3:0] as zero.
- R6: The selectors are at offset 0x10 (interrupt), 0x14 (branch) and 0x18 (wait). Each holds its mask in bits [23:16] and its value in bits [7:0]. Bits [31:24] and [15:8] read as zero.
- R7: Each condition is 1 exactly when (mask & status[7:0]) == value. Status bits [15:8] never affect it.
- R8: When dev_stat_vld is 1, status[7:0] loads dev_stat on the next clock edge and status[15:8] is unchanged.
- R9: When a control write and a device load fall in the same cycle, enabled control bits take the control value. The other low-byte bits take the device value.
- R10: Each descriptor mode field is decoded as 00 = never, 01 = when the condition is 1, 10 = when the condition is 0, 11 = always. The field drives take_interrupt, take_branch or do_wait combinationally.
- R11: Reads at unmapped offsets (for example 0x08 and 0x1C) return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| dev_stat_vld | input | 1 | Device status load strobe |
| dev_stat | input | 8 | Device status byte |
| desc_int_mode | input | 2 | Descriptor interrupt decision field |
| desc_br_mode | input | 2 | Descriptor branch decision field |
| desc_wait_mode | input | 2 | Descriptor wait decision field |
| cond_int | output | 1 | Interrupt condition |
| cond_br | output | 1 | Branch condition |
| cond_wait | output | 1 | Wait condition |
| take_interrupt | output | 1 | Resolved interrupt decision |
| take_branch | output | 1 | Resolved branch decision |
| do_wait | output | 1 | Resolved wait decision |

## Verification
A status bit merged under the wrong enable shows in the status read in the cycle after the write. It also flips a condition output in that same cycle whenever the bit lies in the low byte. A selector that latched the wrong byte lane shows at once in its read-back, where the reserved lanes would no longer be zero. A mis-ordered merge between device and software updates shows only when both arrive together, so that case is driven on purpose. Decision errors are combinational and show in the same cycle as the mode field is presented.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
    localparam int DATA_W = 32;
    localparam int STAT_W = DATA_W / 2;
    localparam int DEV_W  = 8;
    localparam int NUM_SEL = 3;

    localparam int OFF_CTL  = 'h00;
    localparam int OFF_STAT = 'h04;
    localparam int OFF_PTR  = 'h0C;
    localparam int OFF_SEL0 = 'h10;
    localparam int SEL_STRIDE = 4;

    localparam int IDX_INT  = 0;
    localparam int IDX_BR   = 1;
    localparam int IDX_WAIT = 2;

    typedef enum logic [1:0] {
        MODE_NEVER    = 2'b00,
        MODE_IF_TRUE  = 2'b01,
        MODE_IF_FALSE = 2'b10,
        MODE_ALWAYS   = 2'b11
    } dec_mode_e;
endpackage

// File: rtl/dcr_status.sv
module dcr_status
    import dcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [STAT_W-1:0] ctl_en,
    input  logic [STAT_W-1:0] ctl_val,
    input  logic              dev_we,
    input  logic [DEV_W-1:0]  dev_val,
    output logic [STAT_W-1:0] stat
);
    typedef struct packed {
        logic [STAT_W-1:0] word;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (dev_we) begin
            st_d.word[DEV_W-1:0] = dev_val;
        end
        if (ctl_we) begin
            st_d.word = (st_d.word & ~ctl_en) | (ctl_val & ctl_en);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat = st_q.word;

    // R2: enabled bits follow the control value
    a_r2_enabled_bits: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> (((stat ^ $past(ctl_val)) & $past(ctl_en)) == '0));

    // R2: disabled bits hold when the device is idle
    a_r2_disabled_hold: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && !dev_we) |=> (((stat ^ $past(stat)) & ~$past(ctl_en)) == '0));

    // R8: a device load never touches the upper byte
    a_r8_upper_kept: assert property (@(posedge clk) disable iff (rst)
        (dev_we && !ctl_we) |=> (stat[STAT_W-1:DEV_W] == $past(stat[STAT_W-1:DEV_W])));

    // R8: a device load lands in the low byte
    a_r8_low_loaded: assert property (@(posedge clk) disable iff (rst)
        (dev_we && !ctl_we) |=> (stat[DEV_W-1:0] == $past(dev_val)));
endmodule

// File: rtl/dcr_select.sv
module dcr_select
    import dcr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [DEV_W-1:0] wmask,
    input  logic [DEV_W-1:0] wval,
    input  logic [DEV_W-1:0] dev_bits,
    output logic [DEV_W-1:0] sel_mask,
    output logic [DEV_W-1:0] sel_val,
    output logic             cond
);
    typedef struct packed {
        logic [DEV_W-1:0] mask;
        logic [DEV_W-1:0] val;
    } sel_t;

    sel_t sl_d, sl_q;

    always_comb begin
        sl_d = sl_q;
        if (we) begin
            sl_d.mask = wmask;
            sl_d.val  = wval;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sl_q <= '0;
        end else begin
            sl_q <= sl_d;
        end
    end

    assign sel_mask = sl_q.mask;
    assign sel_val  = sl_q.val;
    assign cond     = ((sl_q.mask & dev_bits) == sl_q.val);

    // R6: a write captures both lanes
    a_r6_capture: assert property (@(posedge clk) disable iff (rst)
        we |=> (sel_mask == $past(wmask) && sel_val == $past(wval)));

    // R7: value bits outside the mask can never match
    a_r7_unreachable: assert property (@(posedge clk) disable iff (rst)
        ((sel_val & ~sel_mask) != '0) |-> !cond);

    // R7: a zero mask with a zero value always matches
    a_r7_trivial: assert property (@(posedge clk) disable iff (rst)
        (sel_mask == '0 && sel_val == '0) |-> cond);
endmodule

// File: rtl/dcr_resolve.sv
module dcr_resolve
    import dcr_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       cond,
    output logic       take
);
    dec_mode_e m;

    always_comb begin
        m = dec_mode_e'(mode);
        unique case (m)
            MODE_NEVER:    take = 1'b0;
            MODE_IF_TRUE:  take = cond;
            MODE_IF_FALSE: take = !cond;
            MODE_ALWAYS:   take = 1'b1;
            default:       take = 1'b0;
        endcase
    end
endmodule

// File: rtl/dma_cond_regs.sv
module dma_cond_regs
    import dcr_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int PTR_ALIGN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dev_stat_vld,
    input  logic [DEV_W-1:0]  dev_stat,
    input  logic [1:0]        desc_int_mode,
    input  logic [1:0]        desc_br_mode,
    input  logic [1:0]        desc_wait_mode,
    output logic              cond_int,
    output logic              cond_br,
    output logic              cond_wait,
    output logic              take_interrupt,
    output logic              take_branch,
    output logic              do_wait
);
    localparam int MASK_LSB = DATA_W / 2;

    typedef struct packed {
        logic [DATA_W-1:0] ptr;
    } ptr_t;

    logic              hit_ctl, hit_stat, hit_ptr;
    logic [STAT_W-1:0] stat;
    logic [DEV_W-1:0]  sel_mask [NUM_SEL];
    logic [DEV_W-1:0]  sel_val  [NUM_SEL];
    logic [NUM_SEL-1:0] cond;
    logic [NUM_SEL-1:0] hit_sel;
    logic [1:0]        modes [NUM_SEL];
    logic [NUM_SEL-1:0] take;
    ptr_t              pt_d, pt_q;

    assign hit_ctl  = (reg_addr == ADDR_W'(OFF_CTL));
    assign hit_stat = (reg_addr == ADDR_W'(OFF_STAT));
    assign hit_ptr  = (reg_addr == ADDR_W'(OFF_PTR));

    dcr_status u_status (
        .clk     (clk),
        .rst     (rst),
        .ctl_we  (reg_wr && hit_ctl),
        .ctl_en  (reg_wdata[DATA_W-1:MASK_LSB]),
        .ctl_val (reg_wdata[STAT_W-1:0]),
        .dev_we  (dev_stat_vld),
        .dev_val (dev_stat),
        .stat    (stat)
    );

    assign modes[IDX_INT]  = desc_int_mode;
    assign modes[IDX_BR]   = desc_br_mode;
    assign modes[IDX_WAIT] = desc_wait_mode;

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
        assign hit_sel[i] = (reg_addr == ADDR_W'(OFF_SEL0 + SEL_STRIDE * i));

        dcr_select u_sel (
            .clk      (clk),
            .rst      (rst),
            .we       (reg_wr && hit_sel[i]),
            .wmask    (reg_wdata[MASK_LSB +: DEV_W]),
            .wval     (reg_wdata[DEV_W-1:0]),
            .dev_bits (stat[DEV_W-1:0]),
            .sel_mask (sel_mask[i]),
            .sel_val  (sel_val[i]),
            .cond     (cond[i])
        );

        dcr_resolve u_res (
            .mode (modes[i]),
            .cond (cond[i]),
            .take (take[i])
        );
    end

    always_comb begin
        pt_d = pt_q;
        if (reg_wr && hit_ptr) begin
            pt_d.ptr = {reg_wdata[DATA_W-1:PTR_ALIGN], {PTR_ALIGN{1'b0}}};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pt_q <= '0;
        end else begin
            pt_q <= pt_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (hit_ctl || hit_stat) begin
            reg_rdata[STAT_W-1:0] = stat;
        end
        if (hit_ptr) begin
            reg_rdata = pt_q.ptr;
        end
        for (int i = 0; i < NUM_SEL; i++) begin
            if (hit_sel[i]) begin
                reg_rdata[MASK_LSB +: DEV_W] = sel_mask[i];
                reg_rdata[DEV_W-1:0]         = sel_val[i];
            end
        end
    end

    assign cond_int       = cond[IDX_INT];
    assign cond_br        = cond[IDX_BR];
    assign cond_wait      = cond[IDX_WAIT];
    assign take_interrupt = take[IDX_INT];
    assign take_branch    = take[IDX_BR];
    assign do_wait        = take[IDX_WAIT];

    // R4: a write to the status offset leaves status untouched
    a_r4_stat_ro: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && hit_stat && !dev_stat_vld) |=> $stable(stat));

    // R5: pointer stays aligned
    a_r5_align: assert property (@(posedge clk) disable iff (rst)
        pt_q.ptr[PTR_ALIGN-1:0] == '0);

    // R3: upper half of a status read is zero
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (hit_ctl || hit_stat) |-> (reg_rdata[DATA_W-1:STAT_W] == '0));

    // R10: never/always field values
    a_r10_never: assert property (@(posedge clk) disable iff (rst)
        (desc_br_mode == 2'b00) |-> !take_branch);
    a_r10_always: assert property (@(posedge clk) disable iff (rst)
        (desc_wait_mode == 2'b11) |-> do_wait);
    a_r10_excl: assert property (@(posedge clk) disable iff (rst)
        (desc_int_mode == 2'b01) |-> (take_interrupt == cond_int));
endmodule

// File: tb/tb_dma_cond_regs.sv
`timescale 1ns/1ps
module tb_dma_cond_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dev_stat_vld = 1'b0;
    logic [7:0]  dev_stat = '0;
    logic [1:0]  desc_int_mode = '0, desc_br_mode = '0, desc_wait_mode = '0;
    logic        cond_int, cond_br, cond_wait;
    logic        take_interrupt, take_branch, do_wait;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dma_cond_regs dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dev_stat_vld(dev_stat_vld), .dev_stat(dev_stat),
        .desc_int_mode(desc_int_mode), .desc_br_mode(desc_br_mode),
        .desc_wait_mode(desc_wait_mode),
        .cond_int(cond_int), .cond_br(cond_br), .cond_wait(cond_wait),
        .take_interrupt(take_interrupt), .take_branch(take_branch),
        .do_wait(do_wait)
    );

    // control write data, expected status afterwards
    localparam logic [47:0] VEC [6] = '{
        {32'hFFFF_1234, 16'h1234},
        {32'h00FF_00AB, 16'h12AB},
        {32'hFF00_5600, 16'h56AB},
        {32'h0000_FFFF, 16'h56AB},
        {32'h0F0F_0000, 16'h50A0},
        {32'hFFFF_0000, 16'h0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic modes(input logic [1:0] mi, input logic [1:0] mb, input logic [1:0] mw);
        desc_int_mode = mi; desc_br_mode = mb; desc_wait_mode = mw;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        rd("R1", 8'h00, 0); rd("R1", 8'h0C, 0); rd("R1", 8'h10, 0);
        rd("R1", 8'h14, 0); rd("R1", 8'h18, 0);
        check("R1", {29'd0, cond_int, cond_br, cond_wait}, 32'd7);

        // R2/R3: table of masked control writes
        for (int i = 0; i < 6; i++) begin
            wr(8'h00, VEC[i][47:16]);
            rd("R2", 8'h00, {16'h0, VEC[i][15:0]});
            rd("R3", 8'h04, {16'h0, VEC[i][15:0]});
        end

        // R4: status offset not writable
        wr(8'h04, 32'hFFFF_FFFF);
        rd("R4", 8'h04, 32'h0);

        // R5: pointer alignment
        wr(8'h0C, 32'h1234_567F);
        rd("R5", 8'h0C, 32'h1234_5670);

        // R6: selector lanes, reserved zero
        wr(8'h10, 32'hAAFF_BB0F);
        rd("R6", 8'h10, 32'h00FF_000F);
        check("R7", {31'd0, cond_int}, 32'd0);

        // R7: condition follows low status byte only
        wr(8'h00, 32'hFFFF_000F);
        check("R7", {31'd0, cond_int}, 32'd1);
        wr(8'h00, 32'hFF00_FF00);
        rd("R7", 8'h00, 32'h0000_FF0F);
        check("R7", {31'd0, cond_int}, 32'd1);
        wr(8'h14, 32'h000F_000F);
        wr(8'h18, 32'h0000_0001);
        rd("R6", 8'h18, 32'h0000_0001);
        check("R7", {29'd0, cond_int, cond_br, cond_wait}, 32'b110);

        // R10: decode with int=1, wait=0
        modes(2'b00, 2'b01, 2'b01);
        check("R10", {29'd0, take_interrupt, take_branch, do_wait}, 32'b010);
        modes(2'b01, 2'b10, 2'b10);
        check("R10", {29'd0, take_interrupt, take_branch, do_wait}, 32'b101);
        modes(2'b10, 2'b11, 2'b11);
        check("R10", {29'd0, take_interrupt, take_branch, do_wait}, 32'b011);
        modes(2'b11, 2'b00, 2'b00);
        check("R10", {29'd0, take_interrupt, take_branch, do_wait}, 32'b100);

        // R8: device load of low byte
        @(negedge clk);
        dev_stat = 8'h3C; dev_stat_vld = 1'b1;
        @(negedge clk);
        dev_stat_vld = 1'b0;
        rd("R8", 8'h04, 32'h0000_FF3C);
        check("R8", {31'd0, cond_int}, 32'd0);

        // R9: simultaneous software and device update
        @(negedge clk);
        reg_addr = 8'h00; reg_wdata = 32'h000F_0005; reg_wr = 1'b1;
        dev_stat = 8'hA0; dev_stat_vld = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; dev_stat_vld = 1'b0;
        rd("R9", 8'h00, 32'h0000_FFA5);

        // R11: unmapped offsets
        rd("R11", 8'h08, 32'h0);
        rd("R11", 8'h1C, 32'h0);

        // R1: reset again clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd("R1", 8'h00, 0); rd("R1", 8'h0C, 0); rd("R1", 8'h14, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule